// File: doc/BRIEF.md
# Region-Dependent Bus Cycle Timer

This block measures out each processor bus cycle in master-clock ticks. A cycle begins when a start request arrives while the block is ready. The block looks at the 24-bit address, a memory-or-internal flag and a fast-ROM switch, and from them picks a length of 6, 8 or 12 ticks. When that many ticks have passed, it raises a one-tick done pulse. It returns to ready on the tick after that pulse.

Alongside the bus timing, the block runs a free counter over the 1364-tick scanline. From that counter it gives:
- a dot strobe, every fourth tick;
- a line-start strobe, when the counter wraps;
- a stall flag, high for a fixed 40-tick window that begins at line tick 536.

A bus cycle whose ticks would land in that window is stretched by the whole 40 ticks, so the processor is held across the window.

The address decode works on the bank (upper eight bits) and the offset (lower sixteen bits):
- **Low banks** are banks 0x00–0x3F and 0x80–0xBF. The work RAM, register and joypad decodes below apply only in these banks.
- **Work RAM** is banks 0x7E–0x7F, plus offsets 0x0000–0x1FFF of a low bank.
- **Registers** are offsets 0x2000–0x5FFF of a low bank.
- **Joypad** is offsets 0x4016 and 0x4017 of a low bank. These two offsets take precedence over the register decode.
- **ROM** is every other address.

Top module: `bus_cycle_timer`

## Requirements
- R1: While reset is high and on the first tick after it, ready=1, done=0, line_pos=0, line_start=0.
- R2: A cycle with is_mem=0 lasts 6 ticks, whatever the address or fast-ROM bit.
- R3: A ROM access lasts 6 ticks when addr[23]=1 and fast_rom=1, and 8 ticks otherwise.
- R4: A work RAM access lasts 8 ticks.
- R5: A register access, other than the two joypad offsets, lasts 6 ticks.
- R6: An access at offset 0x4016 or 0x4017 of a low bank lasts 12 ticks.
- R7: Acceptance and completion:
  - A start is accepted at a clock edge where start=1 and ready=1.
  - After acceptance, ready is 0. Done is high only on the L-th tick after acceptance, where L is the cycle length.
  - Ready returns to 1 on the next tick.
  - Start, addr, is_mem and fast_rom are ignored while ready=0.
- R8: line_pos counts 0 to 1363 and then wraps to 0. line_start is high only on the tick where line_pos is 0 following a wrap.
- R9: dot_tick is high exactly when line_pos mod 4 equals 3.
- R10: stall is high exactly when line_pos is in 536..575.
- R11: Let p be the line_pos on the accepting tick. If any of the positions p+1..p+L falls in 536..575, the done pulse comes 40 ticks later than it would otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one tick per edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Cycle start request |
| addr | input | 24 | Bus address, bank in [23:16] |
| is_mem | input | 1 | 1 = cycle touches memory, 0 = internal cycle |
| fast_rom | input | 1 | Fast-ROM enable |
| ready | output | 1 | Idle, a start will be accepted |
| done | output | 1 | One-tick pulse on the last tick of a cycle |
| line_pos | output | 11 | Tick position within the scanline |
| dot_tick | output | 1 | Dot strobe, every fourth tick |
| line_start | output | 1 | Pulse on the first tick of a new line |
| stall | output | 1 | Processor stall window active |

## Verification
A bus cycle and the scanline stall window can coincide. When they do, the cycle length and the window extension add together. The bench issues long back-to-back runs of cycles of mixed lengths, so their start positions drift across every part of the line and through the window. It also places an 8-tick cycle at directed positions just before, just inside and just after the window edges. For each cycle, the bench takes the line position sampled at acceptance and computes arithmetically whether that cycle's tick span meets the window. It then checks the done pulse against the base length, or against the base length plus 40.

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer #(
  parameter int LINE_TICKS  = 1364,
  parameter int DOT_TICKS   = 4,
  parameter int STALL_AT    = 536,
  parameter int STALL_TICKS = 40,
  parameter int FAST_TICKS  = 6,
  parameter int SLOW_TICKS  = 8,
  parameter int XSLOW_TICKS = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [23:0] addr,
  input  logic        is_mem,
  input  logic        fast_rom,
  output logic        ready,
  output logic        done,
  output logic [10:0] line_pos,
  output logic        dot_tick,
  output logic        line_start,
  output logic        stall
);
  localparam int POS_W = $clog2(LINE_TICKS);
  localparam int REM_W = $clog2(XSLOW_TICKS + STALL_TICKS + 1);
  localparam int STALL_END = STALL_AT + STALL_TICKS;

  logic [POS_W-1:0] pos;
  logic [REM_W-1:0] rem;
  logic [7:0]  bank;
  logic [15:0] off;
  logic low_bank, is_wram, is_joy, is_reg;
  logic [REM_W-1:0] base_len, total_len;
  logic [POS_W:0] first_t, last_t;
  logic hit;
  logic accept;

  assign bank     = addr[23:16];
  assign off      = addr[15:0];
  assign low_bank = ~bank[6];
  assign is_wram  = (bank[7:1] == 7'h3F) || (low_bank && off < 16'h2000);
  assign is_joy   = low_bank && (off[15:1] == 15'h200B);
  assign is_reg   = low_bank && off >= 16'h2000 && off < 16'h6000;

  always_comb begin
    if (!is_mem)       base_len = REM_W'(FAST_TICKS);
    else if (is_joy)   base_len = REM_W'(XSLOW_TICKS);
    else if (is_wram)  base_len = REM_W'(SLOW_TICKS);
    else if (is_reg)   base_len = REM_W'(FAST_TICKS);
    else if (addr[23] && fast_rom) base_len = REM_W'(FAST_TICKS);
    else               base_len = REM_W'(SLOW_TICKS);
  end

  assign first_t   = {1'b0, pos} + (POS_W+1)'(1);
  assign last_t    = {1'b0, pos} + (POS_W+1)'(base_len);
  assign hit       = (first_t < (POS_W+1)'(STALL_END)) && (last_t >= (POS_W+1)'(STALL_AT));
  assign total_len = hit ? base_len + REM_W'(STALL_TICKS) : base_len;

  assign ready    = (rem == '0);
  assign done     = (rem == REM_W'(1));
  assign accept   = start && ready;
  assign line_pos = 11'(pos);
  assign dot_tick = (int'(pos) % DOT_TICKS) == DOT_TICKS - 1;
  assign stall    = pos >= POS_W'(STALL_AT) && pos < POS_W'(STALL_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos        <= '0;
      line_start <= 1'b0;
    end else begin
      pos        <= (pos == POS_W'(LINE_TICKS - 1)) ? '0 : pos + POS_W'(1);
      line_start <= (pos == POS_W'(LINE_TICKS - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rem <= '0;
    else if (accept) rem <= total_len;
    else if (!ready) rem <= rem - REM_W'(1);
  end

  // R7
  done_then_ready_chk: assert property (@(posedge clk) disable iff (rst) done |=> ready);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst) accept |=> !ready);
  // R8
  line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (pos == POS_W'(LINE_TICKS - 1)) |=> (pos == '0 && line_start));
  // R10
  stall_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> (pos == POS_W'(STALL_AT)));
endmodule

// File: tb/tb_bus_cycle_timer.sv
module tb_bus_cycle_timer;
  logic clk = 0, rst = 1, start = 0, is_mem = 0, fast_rom = 0;
  logic [23:0] addr = '0;
  logic ready, done, dot_tick, line_start, stall;
  logic [10:0] line_pos;
  int vectors = 0, errors = 0;
  bit finished = 0, mon_on = 0;

  bus_cycle_timer dut (.clk(clk), .rst(rst), .start(start), .addr(addr), .is_mem(is_mem),
    .fast_rom(fast_rom), .ready(ready), .done(done), .line_pos(line_pos),
    .dot_tick(dot_tick), .line_start(line_start), .stall(stall));

  always #2 clk = ~clk;

  function automatic void chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  // region: 0 internal, 1 rom, 2 wram, 3 reg, 4 joy
  function automatic int region(logic [23:0] a, logic m);
    int b = int'(a[23:16]);
    int o = int'(a[15:0]);
    bit lo = (b < 'h40) || (b >= 'h80 && b < 'hC0);
    if (!m) return 0;
    if (lo && (o == 'h4016 || o == 'h4017)) return 4;
    if (b == 'h7E || b == 'h7F || (lo && o < 'h2000)) return 2;
    if (lo && o >= 'h2000 && o <= 'h5FFF) return 3;
    return 1;
  endfunction

  function automatic int base_len(logic [23:0] a, logic m, logic f);
    case (region(a, m))
      0: return 6;
      2: return 8;
      3: return 6;
      4: return 12;
      default: return (a[23] && f) ? 6 : 8;
    endcase
  endfunction

  // scanline monitor: R8, R9, R10
  int epos = 0;
  bit wrapped = 0;
  always @(negedge clk) if (mon_on && !finished) begin
    chk(line_pos == 11'(epos), "R8 line_pos", int'(line_pos), epos);
    chk(line_start == (wrapped && epos == 0), "R8 line_start", int'(line_start), int'(wrapped && epos == 0));
    chk(dot_tick == (epos % 4 == 3), "R9 dot_tick", int'(dot_tick), int'(epos % 4 == 3));
    chk(stall == (epos >= 536 && epos < 576), "R10 stall", int'(stall), int'(epos >= 536 && epos < 576));
    if (epos == 1363) begin epos = 0; wrapped = 1; end else epos++;
  end

  task automatic run_cycle(logic [23:0] a, logic m, logic f);
    int p, exp, n, r;
    string tag;
    bit ext;
    while (!ready) @(negedge clk);
    p = int'(line_pos);
    start = 1; addr = a; is_mem = m; fast_rom = f;
    exp = base_len(a, m, f);
    ext = (p + 1 <= 575) && (p + exp >= 536);
    if (ext) exp += 40;
    r = region(a, m);
    tag = ext ? "R11" : (r == 0 ? "R2" : r == 1 ? "R3" : r == 2 ? "R4" : r == 3 ? "R5" : "R6");
    @(negedge clk);
    addr = 24'h004016; is_mem = 1; fast_rom = ~f;
    n = 0;
    forever begin
      n++;
      if (ready) begin chk(0, "R7 ready while busy", 1, 0); break; end
      if (done || n > 80) break;
      @(negedge clk);
    end
    start = 0;
    chk(done && n == exp, tag, n, exp);
    @(negedge clk);
    chk(ready && !done, "R7 ready after done", int'(ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ready && !done && line_pos == 0 && !line_start, "R1 in reset", int'(ready), 1);
    rst = 0;
    mon_on = 1;
    chk(ready && !done && line_pos == 0 && !line_start, "R1 after reset", int'(line_pos), 0);
    begin
      int offs[10] = '{'h0000, 'h1FFF, 'h2000, 'h4015, 'h4016, 'h4017, 'h5FFF, 'h6000, 'h8000, 'hFFFF};
      for (int b = 0; b < 256; b++) begin
        run_cycle({8'(b), 16'h8000}, 0, 1);
        for (int f = 0; f < 2; f++)
          for (int k = 0; k < 10; k++)
            run_cycle({8'(b), 16'(offs[k])}, 1, 1'(f));
      end
    end
    begin
      int edges[8] = '{526, 527, 528, 529, 573, 574, 575, 576};
      for (int k = 0; k < 8; k++) begin
        while (int'(line_pos) != edges[k]) @(negedge clk);
        run_cycle(24'h7E1234, 1, 0);
      end
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule